// File: doc/BRIEF.md
# Packed Horizontal Subtraction Unit

This block takes two packed vectors of signed integers, A and B, and subtracts neighbouring elements within each vector. Inside an operand, the element at each even index has the element just above it subtracted from it. The differences that come from A are packed into the low half of the result, and the differences that come from B go into the high half. The unit never subtracts lane by lane between A and B.

Three mode inputs choose how the vectors are read. The vector can be the full 128-bit operand or only its low 64 bits. The elements can be 16 or 32 bits wide. For 16-bit elements, each difference can either wrap or be clamped to the signed 16-bit range. The datapath has one register stage. A result is captured together with its valid flag one clock after the inputs are accepted. It is then held until the next accepted input.

Top module: `hsub_unit`

## Requirements
- R1: Each result element equals element 2i minus element 2i+1 of the same operand. Elements are signed and packed from bit 0 upward. Without saturation, only the low element-width bits of the difference are kept (two's-complement wrap).
- R2: With wide_i=1 (128-bit vectors), the A differences go in result elements 0 to N/2-1 and the B differences go in elements N/2 to N-1. N is 8 when elem32_i=0 (16-bit elements) and 4 when elem32_i=1 (32-bit elements).
- R3: With wide_i=0 (64-bit vectors), only bits 63:0 of each operand are used. For 16-bit elements, result elements 0-1 come from A and elements 2-3 come from B. For 32-bit elements, the result holds A0-A1 in bits 31:0 and B0-B1 in bits 63:32. Bits 127:64 of res_o are zero.
- R4: With sat_i=1 and elem32_i=0, each 16-bit difference is computed at 17 bits. Values above 32767 become 16'h7FFF and values below -32768 become 16'h8000.
- R5: sat_i=1 together with elem32_i=1 gives the wrapped 32-bit result and sets mode_err_o to 1. Every other mode sets mode_err_o to 0.
- R6: valid_o equals valid_i one clock earlier. res_o and mode_err_o show the result of an accepted input one clock after it.
- R7: While rst_ni is low, valid_o, res_o and mode_err_o are 0.
- R8: While valid_i is low, res_o and mode_err_o keep their values, whatever the operand and mode inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| wide_i | input | 1 | 1: 128-bit vectors, 0: 64-bit vectors |
| elem32_i | input | 1 | 1: 32-bit elements, 0: 16-bit elements |
| sat_i | input | 1 | 1: saturate 16-bit differences |
| a_i | input | 128 | Operand A |
| b_i | input | 128 | Operand B |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Packed differences |
| mode_err_o | output | 1 | Saturation was requested with 32-bit elements |

## Verification
Every output change is due exactly one clock after a cycle with valid_i high, because the datapath has a single register. The bench drives inputs on the falling edge and drops valid_i on the next falling edge. It then reads res_o, mode_err_o and valid_o there, half a clock after the capturing edge. Hold behaviour is checked one full clock after the operands change while valid_i is low, and is compared with the previously captured value. Expected values come from a behavioural loop over element pairs. That loop is written separately from the generated datapath and is fed with random operands and with the directed extremes.

// File: rtl/hsub_pkg.sv
package hsub_pkg;
  parameter int unsigned VEC_W  = 128;
  parameter int unsigned HALF_W = VEC_W / 2;
  parameter int unsigned E16_W  = 16;
  parameter int unsigned E32_W  = 32;
  parameter int unsigned P16    = VEC_W / (2 * E16_W);  // 16-bit pairs per full operand
  parameter int unsigned P32    = VEC_W / (2 * E32_W);  // 32-bit pairs per full operand
endpackage

// File: rtl/hsub_pair.sv
module hsub_pair #(
  parameter int unsigned EW = 16
) (
  input  logic [EW-1:0] even_i,
  input  logic [EW-1:0] odd_i,
  input  logic          sat_i,
  output logic [EW-1:0] diff_o
);
  logic [EW:0] full;
  logic        ovf;

  // one guard bit: overflow shows as disagreement of the top two bits
  assign full = {even_i[EW-1], even_i} - {odd_i[EW-1], odd_i};
  assign ovf  = full[EW] ^ full[EW-1];

  always_comb begin
    if (sat_i && ovf) diff_o = {full[EW], {(EW-1){~full[EW]}}};
    else              diff_o = full[EW-1:0];
  end
endmodule

// File: rtl/hsub_pack.sv
module hsub_pack
  import hsub_pkg::*;
(
  input  logic [P16-1:0][E16_W-1:0] d16_a_i,
  input  logic [P16-1:0][E16_W-1:0] d16_b_i,
  input  logic [P32-1:0][E32_W-1:0] d32_a_i,
  input  logic [P32-1:0][E32_W-1:0] d32_b_i,
  input  logic                      wide_i,
  input  logic                      elem32_i,
  output logic [VEC_W-1:0]          res_o
);
  localparam int unsigned H16 = P16 / 2;
  localparam int unsigned H32 = P32 / 2;

  always_comb begin
    res_o = '0;
    if (elem32_i) begin
      if (wide_i) res_o = {d32_b_i, d32_a_i};
      else        res_o[HALF_W-1:0] = {d32_b_i[H32-1:0], d32_a_i[H32-1:0]};
    end else begin
      if (wide_i) res_o = {d16_b_i, d16_a_i};
      else        res_o[HALF_W-1:0] = {d16_b_i[H16-1:0], d16_a_i[H16-1:0]};
    end
  end
endmodule

// File: rtl/hsub_unit.sv
module hsub_unit
  import hsub_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             wide_i,
  input  logic             elem32_i,
  input  logic             sat_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o,
  output logic             mode_err_o
);
  logic [P16-1:0][E16_W-1:0] d16_a, d16_b;
  logic [P32-1:0][E32_W-1:0] d32_a, d32_b;
  logic [VEC_W-1:0]          res_c;
  logic                      err_c;

  for (genvar g = 0; g < P16; g++) begin : g_p16
    hsub_pair #(.EW(E16_W)) i_pa (
      .even_i(a_i[2*g*E16_W +: E16_W]), .odd_i(a_i[(2*g+1)*E16_W +: E16_W]),
      .sat_i (sat_i), .diff_o(d16_a[g]));
    hsub_pair #(.EW(E16_W)) i_pb (
      .even_i(b_i[2*g*E16_W +: E16_W]), .odd_i(b_i[(2*g+1)*E16_W +: E16_W]),
      .sat_i (sat_i), .diff_o(d16_b[g]));
  end

  // 32-bit lanes never saturate; an illegal request is flagged instead
  for (genvar g = 0; g < P32; g++) begin : g_p32
    hsub_pair #(.EW(E32_W)) i_pa (
      .even_i(a_i[2*g*E32_W +: E32_W]), .odd_i(a_i[(2*g+1)*E32_W +: E32_W]),
      .sat_i (1'b0), .diff_o(d32_a[g]));
    hsub_pair #(.EW(E32_W)) i_pb (
      .even_i(b_i[2*g*E32_W +: E32_W]), .odd_i(b_i[(2*g+1)*E32_W +: E32_W]),
      .sat_i (1'b0), .diff_o(d32_b[g]));
  end

  hsub_pack i_pack (
    .d16_a_i (d16_a), .d16_b_i (d16_b),
    .d32_a_i (d32_a), .d32_b_i (d32_b),
    .wide_i  (wide_i), .elem32_i(elem32_i),
    .res_o   (res_c)
  );

  assign err_c = sat_i & elem32_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      res_o      <= '0;
      mode_err_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o      <= res_c;
        mode_err_o <= err_c;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R6
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R6
  AST_HOLD_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o) && $stable(mode_err_o));  // R8
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> res_o[VEC_W-1:HALF_W] == '0);  // R3
  AST_ILLEGAL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sat_i && elem32_i) |=> mode_err_o);  // R5
  AST_SAT_LOW_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sat_i && !elem32_i && a_i[15:0] == 16'h8000 && a_i[31:16] == 16'h0001)
    |=> res_o[15:0] == 16'h8000);  // R4
endmodule

// File: tb/test_hsub_unit.sv
`timescale 1ns/1ps
module test_hsub_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0, wide = 1'b0, e32 = 1'b0, sat = 1'b0;
  logic [127:0] a = '0, b = '0;
  logic         valid_o, mode_err_o;
  logic [127:0] res_o;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  hsub_unit i_hsub_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .wide_i(wide), .elem32_i(e32),
    .sat_i(sat), .a_i(a), .b_i(b), .valid_o(valid_o), .res_o(res_o), .mode_err_o(mode_err_o));

  function automatic logic [127:0] ref_hsub(input logic [127:0] x, y,
                                            input logic w, e, s);
    int ew = e ? 32 : 16;
    int h  = ((w ? 128 : 64) / ew) / 2;
    logic [127:0] r = '0;
    for (int op = 0; op < 2; op++) begin
      logic [127:0] v = (op == 0) ? x : y;
      for (int k = 0; k < h; k++) begin
        longint p, q, d;
        if (e) begin
          p = longint'($signed(v[2*k*32 +: 32])); q = longint'($signed(v[(2*k+1)*32 +: 32]));
        end else begin
          p = longint'($signed(v[2*k*16 +: 16])); q = longint'($signed(v[(2*k+1)*16 +: 16]));
        end
        d = p - q;
        if (s && !e) begin
          if (d > 32767) d = 32767;
          if (d < -32768) d = -32768;
        end
        if (e) r[(op*h + k)*32 +: 32] = d[31:0];
        else   r[(op*h + k)*16 +: 16] = d[15:0];
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [127:0] x, y, input logic w, e, s, input string req);
    logic [127:0] exp;
    @(negedge clk);
    a = x; b = y; wide = w; e32 = e; sat = s; valid = 1'b1;
    exp = ref_hsub(x, y, w, e, s);
    @(negedge clk);
    valid = 1'b0;
    chk(res_o == exp, req, res_o, exp);
    chk(mode_err_o == (s & e), "R5", 128'(mode_err_o), 128'(s & e));
    chk(valid_o == 1'b1, "R6", 128'(valid_o), 128'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] prev;
    logic         prev_err;
    void'($urandom(32'd7151));
    a = '1; b = '1; valid = 1'b1; wide = 1'b1; sat = 1'b1;
    #5;
    chk(res_o == '0 && valid_o == 1'b0 && mode_err_o == 1'b0, "R7", res_o, '0);
    @(negedge clk); valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R1/R4 corners: min minus one, max minus minus-one, equal pairs
    run({96'h0, 16'h0001, 16'h8000}, '0, 1'b1, 1'b0, 1'b0, "R1 wrap min-1");
    run({96'h0, 16'h0001, 16'h8000}, '0, 1'b1, 1'b0, 1'b1, "R4 clamp min-1");
    run({96'h0, 16'hFFFF, 16'h7FFF}, '0, 1'b1, 1'b0, 1'b0, "R1 wrap max+1");
    run({96'h0, 16'hFFFF, 16'h7FFF}, '0, 1'b1, 1'b0, 1'b1, "R4 clamp max+1");
    run({8{16'h1234}}, {8{16'h8000}}, 1'b1, 1'b0, 1'b1, "R4 equal pairs");
    run({64'h0, 32'h0000_0001, 32'h8000_0000}, '0, 1'b1, 1'b1, 1'b0, "R1 wrap32");
    run({64'h0, 32'h0000_0001, 32'h8000_0000}, '0, 1'b1, 1'b1, 1'b1, "R5 illegal sat32");
    // R2 placement: distinct values per lane
    run({16'd1,16'd9,16'd2,16'd20,16'd3,16'd30,16'd4,16'd40},
        {16'd5,16'd50,16'd6,16'd60,16'd7,16'd70,16'd8,16'd80}, 1'b1, 1'b0, 1'b0, "R2 place16");
    run({32'd1,32'd9,32'd2,32'd20}, {32'd3,32'd30,32'd4,32'd40}, 1'b1, 1'b1, 1'b0, "R2 place32");
    // R3 narrow with garbage in upper halves
    run({64'hDEAD_BEEF_0BAD_F00D, 16'd1,16'd9,16'd2,16'd20},
        {64'hFFFF_FFFF_FFFF_FFFF, 16'd3,16'd30,16'd4,16'd40}, 1'b0, 1'b0, 1'b0, "R3 narrow16");
    run({64'hDEAD_BEEF_0BAD_F00D, 32'd7, 32'd100}, {64'h1, 32'd5, 32'd50}, 1'b0, 1'b1, 1'b0, "R3 narrow32");

    // R8: change everything with valid low, output must hold
    prev = res_o; prev_err = mode_err_o;
    @(negedge clk);
    a = {4{$urandom}}; b = {4{$urandom}}; sat = 1'b1; e32 = 1'b1; wide = ~wide;
    @(negedge clk);
    chk(res_o == prev && mode_err_o == prev_err, "R8", res_o, prev);
    chk(valid_o == 1'b0, "R6", 128'(valid_o), 128'd0);

    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 30; n++) begin
        logic [127:0] ra, rb;
        string tag;
        ra = {$urandom, $urandom, $urandom, $urandom};
        rb = {$urandom, $urandom, $urandom, $urandom};
        if (n % 5 == 0) ra[31:0] = {16'h8000, 16'h7FFF};
        if (n % 7 == 0) rb[63:32] = {16'h7FFF, 16'h8000};
        tag = m[1] ? (m[2] ? "R5 rand" : "R1 R4 rand") : (m[0] ? "R2 rand" : "R3 rand");
        run(ra, rb, m[0], m[2], m[1], tag);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule